// File: doc/BRIEF.md
# Binary32 Special-Operand Resolver

This combinational block sits next to a single-precision arithmetic datapath. It looks at the two operand words and the operation code. It decides whether the special values among the operands already fix the result. The special values are zeros, infinities and NaNs. When they do, the block raises `special_o` and supplies the final result word, together with the invalid-operation flag `nv_o` and the divide-by-zero flag `dz_o`. When they do not, `special_o` stays low and the surrounding pipeline takes the datapath's own result.

Rounding, the finite arithmetic and overflow or underflow detection belong to the datapath. The block only resolves the IEEE-754 cases that follow from operand classes. Every NaN it produces is the canonical quiet NaN `0x7FC00000`. The exponent and fraction widths are parameters; the defaults give binary32.

Top module: `fp_special_resolver`

## Requirements
- R1: An operand is classified by its fields. With exponent all ones, a zero fraction is an infinity, a fraction with its top bit (bit 22) set is a quiet NaN, and a non-zero fraction with bit 22 clear is a signalling NaN. With exponent zero, a zero fraction is a zero of either sign and a non-zero fraction is a subnormal. Any other exponent marks a normal number, and normal and subnormal operands count as finite.
- R2: `op_i` encodes 0 = add, 1 = subtract (a - b), 2 = multiply, 3 = divide (a / b) and 4 = square root of a. Codes 5 to 7 behave exactly as add.
- R3: If an operand used by the operation is a NaN, the outputs are `special_o`=1, `result_o`=0x7FC00000 and `dz_o`=0.
- R4: In the NaN case of R3, `nv_o` is 1 when a used operand is a signalling NaN and 0 when the NaNs are only quiet.
- R5: For add and subtract, two infinities with opposite effective signs give `nv_o`=1 and the canonical quiet NaN. The effective sign of b is its sign inverted for subtract.
- R6: For multiply, zero times infinity in either order gives `nv_o`=1 and the canonical quiet NaN.
- R7: For divide, 0/0 and infinity/infinity give `nv_o`=1 and the canonical quiet NaN.
- R8: Square root of a negative subnormal, normal or infinity gives `nv_o`=1 and the canonical quiet NaN. Square root of -0 is not special. Square root never looks at b, even when b is a NaN.
- R9: For divide, a finite dividend over a zero divisor gives `dz_o`=1 and an infinity whose sign is the XOR of the operand signs. An infinite dividend over zero gives the infinity with `dz_o`=0.
- R10: Infinite results are reported as special with both flags low. Add or subtract with one infinity, or with infinities of the same effective sign, takes the sign of the infinite term. Multiply of an infinity by a non-zero number, and divide of an infinity by a finite number or zero, use the XOR of the signs. Square root of +infinity gives +infinity.
- R11: For divide, a finite or zero dividend over an infinite divisor gives `special_o`=1 and a zero whose sign is the XOR of the operand signs.
- R12: When none of R3 to R11 applies, `special_o`, `nv_o` and `dz_o` are 0 and `result_o` is 0.
- R13: `nv_o` and `dz_o` are never high together, and either flag implies `special_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand (dividend, minuend, radicand) |
| b_i | input | 32 | Second operand, unused for square root |
| op_i | input | 3 | Operation code (see R2) |
| special_o | output | 1 | Result is fixed by special operands |
| result_o | output | 32 | Resolved result word, zero when not special |
| nv_o | output | 1 | Invalid-operation flag |
| dz_o | output | 1 | Divide-by-zero flag |

## Verification
The hardest situations to reach are at the edges of the class boundaries. One is the fraction that is exactly `0x400000` under an all-ones exponent, which is a quiet NaN with an empty payload. Another is its neighbour `0x3FFFFF`, which is signalling. A third is a dividend that is the smallest subnormal, which must still count as finite for divide-by-zero. The stimulus places these words directly on the operand ports. It also pairs each invalid case with a near-miss of the same operation: same-sign infinities for add, the reserved operation codes, and -0 or a signalling-NaN b for square root. This confirms that the decision follows operation and sign, not class alone.

// File: rtl/fp_spec_pkg.sv
package fp_spec_pkg;

   localparam int OP_W = 3;

   typedef enum logic [OP_W-1:0] {
      OP_ADD  = 3'd0,
      OP_SUB  = 3'd1,
      OP_MUL  = 3'd2,
      OP_DIV  = 3'd3,
      OP_SQRT = 3'd4
   } op_code_t;

   // Class flags of one operand; exactly one of the class bits is set.
   typedef struct packed {
      logic sign;
      logic is_zero;
      logic is_sub;
      logic is_norm;
      logic is_inf;
      logic is_qnan;
      logic is_snan;
   } opnd_class_t;

   typedef enum logic [1:0] {
      RK_NONE = 2'd0,
      RK_QNAN = 2'd1,
      RK_INF  = 2'd2,
      RK_ZERO = 2'd3
   } res_kind_t;

   typedef struct packed {
      res_kind_t kind;
      logic      sign;
      logic      nv;
      logic      dz;
   } verdict_t;

endpackage

// File: rtl/fp_operand_classifier.sv
module fp_operand_classifier
   import fp_spec_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0] word_i,
   output opnd_class_t           cls_o
);
   localparam int W = 1 + EXP_W + FRAC_W;

   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;
   logic exp_ones, exp_zero, frac_nz, quiet_bit;

   assign exp_f     = word_i[W-2 -: EXP_W];
   assign frac_f    = word_i[FRAC_W-1:0];
   assign exp_ones  = &exp_f;
   assign exp_zero  = ~|exp_f;
   assign frac_nz   = |frac_f;
   assign quiet_bit = frac_f[FRAC_W-1];

   always_comb begin
      cls_o.sign    = word_i[W-1];
      cls_o.is_zero = exp_zero & ~frac_nz;
      cls_o.is_sub  = exp_zero &  frac_nz;
      cls_o.is_norm = ~exp_zero & ~exp_ones;
      cls_o.is_inf  = exp_ones & ~frac_nz;
      cls_o.is_qnan = exp_ones &  quiet_bit;
      cls_o.is_snan = exp_ones &  frac_nz & ~quiet_bit;
   end
endmodule

// File: rtl/fp_exception_logic.sv
module fp_exception_logic
   import fp_spec_pkg::*;
(
   input  opnd_class_t      a_cls_i,
   input  opnd_class_t      b_cls_i,
   input  logic [OP_W-1:0]  op_i,
   output verdict_t         verdict_o
);
   logic a_nan, b_nan, a_fin, use_b;
   logic any_nan, any_snan, eff_b_sign, xsign;

   assign a_nan      = a_cls_i.is_qnan | a_cls_i.is_snan;
   assign b_nan      = b_cls_i.is_qnan | b_cls_i.is_snan;
   assign a_fin      = a_cls_i.is_sub  | a_cls_i.is_norm;
   assign use_b      = (op_i != OP_SQRT);
   assign any_nan    = a_nan | (use_b & b_nan);
   assign any_snan   = a_cls_i.is_snan | (use_b & b_cls_i.is_snan);
   assign eff_b_sign = b_cls_i.sign ^ (op_i == OP_SUB);
   assign xsign      = a_cls_i.sign ^ b_cls_i.sign;

   always_comb begin
      verdict_o = '{kind: RK_NONE, sign: 1'b0, nv: 1'b0, dz: 1'b0};
      if (any_nan) begin
         verdict_o.kind = RK_QNAN;
         verdict_o.nv   = any_snan;
      end else begin
         case (op_i)
            OP_MUL: begin
               if ((a_cls_i.is_zero & b_cls_i.is_inf) | (a_cls_i.is_inf & b_cls_i.is_zero)) begin
                  verdict_o.kind = RK_QNAN;
                  verdict_o.nv   = 1'b1;
               end else if (a_cls_i.is_inf | b_cls_i.is_inf) begin
                  verdict_o.kind = RK_INF;
                  verdict_o.sign = xsign;
               end
            end
            OP_DIV: begin
               if ((a_cls_i.is_zero & b_cls_i.is_zero) | (a_cls_i.is_inf & b_cls_i.is_inf)) begin
                  verdict_o.kind = RK_QNAN;
                  verdict_o.nv   = 1'b1;
               end else if (a_cls_i.is_inf) begin
                  verdict_o.kind = RK_INF;
                  verdict_o.sign = xsign;
               end else if (a_fin & b_cls_i.is_zero) begin
                  verdict_o.kind = RK_INF;
                  verdict_o.sign = xsign;
                  verdict_o.dz   = 1'b1;
               end else if (b_cls_i.is_inf) begin
                  verdict_o.kind = RK_ZERO;
                  verdict_o.sign = xsign;
               end
            end
            OP_SQRT: begin
               if (a_cls_i.sign & (a_fin | a_cls_i.is_inf)) begin
                  verdict_o.kind = RK_QNAN;
                  verdict_o.nv   = 1'b1;
               end else if (a_cls_i.is_inf) begin
                  verdict_o.kind = RK_INF;
                  verdict_o.sign = 1'b0;
               end
            end
            default: begin
               if (a_cls_i.is_inf & b_cls_i.is_inf) begin
                  if (a_cls_i.sign != eff_b_sign) begin
                     verdict_o.kind = RK_QNAN;
                     verdict_o.nv   = 1'b1;
                  end else begin
                     verdict_o.kind = RK_INF;
                     verdict_o.sign = a_cls_i.sign;
                  end
               end else if (a_cls_i.is_inf) begin
                  verdict_o.kind = RK_INF;
                  verdict_o.sign = a_cls_i.sign;
               end else if (b_cls_i.is_inf) begin
                  verdict_o.kind = RK_INF;
                  verdict_o.sign = eff_b_sign;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/fp_result_former.sv
module fp_result_former
   import fp_spec_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  verdict_t              verdict_i,
   output logic                  special_o,
   output logic [EXP_W+FRAC_W:0] word_o
);
   localparam logic [EXP_W-1:0]  EXP_ONES  = {EXP_W{1'b1}};
   localparam logic [FRAC_W-1:0] FRAC_ZERO = '0;
   localparam logic [FRAC_W-1:0] FRAC_QNAN = FRAC_ZERO | (FRAC_W'(1) << (FRAC_W-1));

   assign special_o = (verdict_i.kind != RK_NONE);

   always_comb begin
      case (verdict_i.kind)
         RK_QNAN: word_o = {1'b0, EXP_ONES, FRAC_QNAN};
         RK_INF:  word_o = {verdict_i.sign, EXP_ONES, FRAC_ZERO};
         RK_ZERO: word_o = {verdict_i.sign, {EXP_W{1'b0}}, FRAC_ZERO};
         default: word_o = '0;
      endcase
   end
endmodule

// File: rtl/fp_special_resolver.sv
module fp_special_resolver
   import fp_spec_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0] a_i,
   input  logic [EXP_W+FRAC_W:0] b_i,
   input  logic [OP_W-1:0]       op_i,
   output logic                  special_o,
   output logic [EXP_W+FRAC_W:0] result_o,
   output logic                  nv_o,
   output logic                  dz_o
);
   localparam int W        = 1 + EXP_W + FRAC_W;
   localparam int NUM_OPND = 2;

   generate
      if (EXP_W < 2) begin : g_bad_exp
         $error("fp_special_resolver: EXP_W must be at least 2");
      end
      if (FRAC_W < 2) begin : g_bad_frac
         $error("fp_special_resolver: FRAC_W must be at least 2");
      end
   endgenerate

   logic [W-1:0] opnd_w [NUM_OPND];
   opnd_class_t  opnd_c [NUM_OPND];
   verdict_t     verdict;

   assign opnd_w[0] = a_i;
   assign opnd_w[1] = b_i;

   generate
      for (genvar g = 0; g < NUM_OPND; g++) begin : g_cls
         fp_operand_classifier #(
            .EXP_W (EXP_W),
            .FRAC_W(FRAC_W)
         ) u_cls (
            .word_i(opnd_w[g]),
            .cls_o (opnd_c[g])
         );
      end
   endgenerate

   fp_exception_logic u_exc (
      .a_cls_i  (opnd_c[0]),
      .b_cls_i  (opnd_c[1]),
      .op_i     (op_i),
      .verdict_o(verdict)
   );

   fp_result_former #(
      .EXP_W (EXP_W),
      .FRAC_W(FRAC_W)
   ) u_form (
      .verdict_i(verdict),
      .special_o(special_o),
      .word_o   (result_o)
   );

   assign nv_o = verdict.nv;
   assign dz_o = verdict.dz;
endmodule

// File: rtl/fp_special_resolver_chk.sv
module fp_special_resolver_chk
   import fp_spec_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input logic [EXP_W+FRAC_W:0] a_i,
   input logic [EXP_W+FRAC_W:0] b_i,
   input logic [OP_W-1:0]       op_i,
   input logic                  special_o,
   input logic [EXP_W+FRAC_W:0] result_o,
   input logic                  nv_o,
   input logic                  dz_o
);
   localparam int W = 1 + EXP_W + FRAC_W;

   logic a_e1, b_e1, r_e1, a_nan, b_nan, a_sn, b_sn, b_used, r_inf, r_qnan, a_neg_nz;

   assign a_e1   = &a_i[W-2 -: EXP_W];
   assign b_e1   = &b_i[W-2 -: EXP_W];
   assign r_e1   = &result_o[W-2 -: EXP_W];
   assign a_nan  = a_e1 & (|a_i[FRAC_W-1:0]);
   assign b_nan  = b_e1 & (|b_i[FRAC_W-1:0]);
   assign a_sn   = a_nan & ~a_i[FRAC_W-1];
   assign b_sn   = b_nan & ~b_i[FRAC_W-1];
   assign b_used = (op_i != 3'd4);
   assign r_inf  = r_e1 & ~(|result_o[FRAC_W-1:0]);
   assign r_qnan = r_e1 & result_o[FRAC_W-1];
   assign a_neg_nz = a_i[W-1] & (|a_i[W-2:0]) & ~a_nan;

   always_comb begin
      // R3: a NaN among the used operands yields a NaN and no divide-by-zero
      assert_nan_in_nan_out_R3: assert (!(a_nan || (b_used && b_nan)) || (special_o && r_qnan && !dz_o))
         else $error("R3 NaN input not propagated");
      // R4: a signalling NaN among the used operands raises invalid
      assert_snan_raises_nv_R4: assert (!(a_sn || (b_used && b_sn)) || nv_o)
         else $error("R4 signalling NaN without invalid flag");
      // R8: negative non-zero radicand is invalid
      assert_sqrt_negative_R8: assert (!(op_i == 3'd4 && a_neg_nz) || nv_o)
         else $error("R8 negative square root not flagged");
      // R9: divide-by-zero gives an infinity signed by the operand XOR
      assert_dz_signed_inf_R9: assert (!dz_o || (r_inf && result_o[W-1] == (a_i[W-1] ^ b_i[W-1])))
         else $error("R9 divide-by-zero result is not the signed infinity");
      // R12: not special means quiet outputs
      assert_idle_outputs_R12: assert (special_o || (result_o == '0 && !nv_o && !dz_o))
         else $error("R12 outputs active without special strobe");
      // R13: flags exclusive, and invalid always delivers a quiet NaN
      assert_flags_exclusive_R13: assert (!(nv_o && dz_o) && (!nv_o || (special_o && r_qnan)))
         else $error("R13 flag consistency broken");
   end
endmodule

bind fp_special_resolver fp_special_resolver_chk #(
   .EXP_W (EXP_W),
   .FRAC_W(FRAC_W)
) u_chk (
   .a_i      (a_i),
   .b_i      (b_i),
   .op_i     (op_i),
   .special_o(special_o),
   .result_o (result_o),
   .nv_o     (nv_o),
   .dz_o     (dz_o)
);

// File: tb/fp_special_resolver_test.sv
module fp_special_resolver_test;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 5000;

   localparam logic [31:0] P_ONE  = 32'h3F80_0000;
   localparam logic [31:0] N_ONE  = 32'hBF80_0000;
   localparam logic [31:0] P_INF  = 32'h7F80_0000;
   localparam logic [31:0] N_INF  = 32'hFF80_0000;
   localparam logic [31:0] P_ZERO = 32'h0000_0000;
   localparam logic [31:0] N_ZERO = 32'h8000_0000;
   localparam logic [31:0] QNAN_C = 32'h7FC0_0000;
   localparam logic [31:0] QNAN_P = 32'h7FC1_2345;
   localparam logic [31:0] SNAN_A = 32'h7F80_0001;
   localparam logic [31:0] SNAN_B = 32'hFFBF_FFFF;
   localparam logic [31:0] P_SUB  = 32'h0000_0001;
   localparam logic [31:0] N_SUB  = 32'h8000_0001;
   localparam logic [31:0] P_MAX  = 32'h7F7F_FFFF;

   logic        clk = 1'b0;
   logic [31:0] a_i = '0;
   logic [31:0] b_i = '0;
   logic [2:0]  op_i = 3'd0;
   logic        special_o, nv_o, dz_o;
   logic [31:0] result_o;

   int total = 0;
   int bad   = 0;
   int cycles = 0;
   bit done  = 1'b0;

   typedef struct {
      logic        sp;
      logic [31:0] res;
      logic        nv;
      logic        dz;
      string       tag;
   } exp_t;

   exp_t sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   fp_special_resolver uut (
      .a_i      (a_i),
      .b_i      (b_i),
      .op_i     (op_i),
      .special_o(special_o),
      .result_o (result_o),
      .nv_o     (nv_o),
      .dz_o     (dz_o)
   );

   // Driver: applies a vector on the falling edge and records what must come out.
   task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op,
                        input logic sp, input logic [31:0] res, input logic nv,
                        input logic dz, input string tag);
      exp_t e;
      @(negedge clk);
      a_i  = a;
      b_i  = b;
      op_i = op;
      e.sp = sp; e.res = res; e.nv = nv; e.dz = dz; e.tag = tag;
      sb_q.push_back(e);
   endtask

   // Monitor: on the next rising edge the combinational outputs are settled.
   always @(posedge clk) begin
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         total++;
         if (special_o !== e.sp || result_o !== e.res || nv_o !== e.nv || dz_o !== e.dz) begin
            bad++;
            $display("FAIL %s: actual sp=%0b res=%h nv=%0b dz=%0b expected sp=%0b res=%h nv=%0b dz=%0b",
                     e.tag, special_o, result_o, nv_o, dz_o, e.sp, e.res, e.nv, e.dz);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual cycles=%0d expected below %0d", cycles, WATCHDOG);
         finish_run();
      end
   end

   initial begin
      // R12: starting state and plain finite operands are not special
      drive(P_ZERO, P_ZERO, 3'd0, 0, 32'h0, 0, 0, "R12 start all-zero add");
      drive(P_ONE,  P_ONE,  3'd0, 0, 32'h0, 0, 0, "R12 finite add");
      drive(P_MAX,  P_ZERO, 3'd2, 0, 32'h0, 0, 0, "R12 R1 max normal times zero");
      // R5 / R10: add and subtract infinities
      drive(P_INF,  N_INF,  3'd0, 1, QNAN_C, 1, 0, "R5 +inf + -inf");
      drive(P_INF,  P_INF,  3'd1, 1, QNAN_C, 1, 0, "R5 +inf - +inf");
      drive(P_INF,  N_INF,  3'd1, 1, P_INF,  0, 0, "R10 +inf - -inf");
      drive(P_INF,  P_ONE,  3'd0, 1, P_INF,  0, 0, "R10 +inf + 1");
      drive(P_ONE,  N_INF,  3'd0, 1, N_INF,  0, 0, "R10 1 + -inf");
      drive(P_ONE,  N_INF,  3'd1, 1, P_INF,  0, 0, "R10 1 - -inf");
      // R6: multiply
      drive(P_ZERO, N_INF,  3'd2, 1, QNAN_C, 1, 0, "R6 0 * -inf");
      drive(P_INF,  N_ZERO, 3'd2, 1, QNAN_C, 1, 0, "R6 +inf * -0");
      drive(N_INF,  N_ONE,  3'd2, 1, P_INF,  0, 0, "R10 -inf * -1");
      drive(N_SUB,  P_INF,  3'd2, 1, N_INF,  0, 0, "R10 R1 -subnormal * +inf");
      // R7, R9, R11: divide
      drive(P_ZERO, N_ZERO, 3'd3, 1, QNAN_C, 1, 0, "R7 0 / -0");
      drive(N_INF,  P_INF,  3'd3, 1, QNAN_C, 1, 0, "R7 -inf / +inf");
      drive(P_ONE,  P_ZERO, 3'd3, 1, P_INF,  0, 1, "R9 1 / +0");
      drive(N_ONE,  P_ZERO, 3'd3, 1, N_INF,  0, 1, "R9 -1 / +0");
      drive(P_SUB,  N_ZERO, 3'd3, 1, N_INF,  0, 1, "R9 R1 subnormal / -0");
      drive(N_INF,  P_ZERO, 3'd3, 1, N_INF,  0, 0, "R9 R13 -inf / +0 no dz");
      drive(P_ONE,  N_INF,  3'd3, 1, N_ZERO, 0, 0, "R11 1 / -inf");
      drive(N_ZERO, N_INF,  3'd3, 1, P_ZERO, 0, 0, "R11 -0 / -inf");
      drive(P_ONE,  P_SUB,  3'd3, 0, 32'h0,  0, 0, "R12 finite divide");
      // R8: square root
      drive(N_ONE,  P_ONE,  3'd4, 1, QNAN_C, 1, 0, "R8 sqrt -1");
      drive(N_SUB,  P_ONE,  3'd4, 1, QNAN_C, 1, 0, "R8 sqrt -subnormal");
      drive(N_INF,  P_ONE,  3'd4, 1, QNAN_C, 1, 0, "R8 sqrt -inf");
      drive(N_ZERO, P_ONE,  3'd4, 0, 32'h0,  0, 0, "R8 sqrt -0 not special");
      drive(P_ONE,  SNAN_A, 3'd4, 0, 32'h0,  0, 0, "R8 sqrt ignores snan b");
      drive(P_INF,  N_INF,  3'd4, 1, P_INF,  0, 0, "R10 sqrt +inf");
      // R3 / R4 / R1: NaN handling and classification edges
      drive(QNAN_P, P_ONE,  3'd0, 1, QNAN_C, 0, 0, "R3 quiet NaN plus 1");
      drive(P_ONE,  SNAN_A, 3'd2, 1, QNAN_C, 1, 0, "R4 1 * snan");
      drive(SNAN_B, P_ZERO, 3'd3, 1, QNAN_C, 1, 0, "R3 R4 snan / 0 no dz");
      drive(QNAN_P, P_ZERO, 3'd2, 1, QNAN_C, 0, 0, "R4 qnan * 0 no nv");
      drive(P_ONE,  QNAN_P, 3'd3, 1, QNAN_C, 0, 0, "R3 1 / qnan no dz");
      drive(QNAN_C, P_INF,  3'd1, 1, QNAN_C, 0, 0, "R1 fraction 0x400000 is quiet");
      drive(32'h7FBF_FFFF, P_ONE, 3'd0, 1, QNAN_C, 1, 0, "R1 fraction 0x3FFFFF is signalling");
      drive(SNAN_A, P_ONE,  3'd4, 1, QNAN_C, 1, 0, "R4 sqrt snan");
      // R2: reserved codes behave as add
      drive(P_INF,  N_INF,  3'd5, 1, QNAN_C, 1, 0, "R2 code 5 as add invalid");
      drive(N_INF,  N_INF,  3'd6, 1, N_INF,  0, 0, "R2 code 6 as add same sign");
      drive(P_ONE,  P_ONE,  3'd7, 0, 32'h0,  0, 0, "R2 code 7 finite");
      @(negedge clk);
      @(negedge clk);
      finish_run();
   end
endmodule